// File: doc/BRIEF.md
# Programmable Down-Count Interval Timer

This block is a 32-bit down-counting interval timer for a processor's local interrupt logic. Software picks a power-of-two prescale ratio through a divide-code register, sets up a control entry (interrupt vector, a mask flag and a repeat flag), and then writes a start count. From that write onward the current count falls by one for every 2^shift base ticks. When a decrement step arrives while the count already sits at zero, the timer expires.

On expiry the block emits a one-cycle interrupt request that carries the vector from the control entry, unless the entry is masked. In one-shot mode the count then holds at zero and the timer stays silent until the start count is written again. In repeat mode the count reloads from the start count, so the timer expires every (start+1) * 2^shift ticks. A start count of zero leaves the timer idle.

The register port is a simple write strobe with address and data, plus a combinational read by address. Address 0 is the control entry, 1 the start count, 2 the current count (read-only) and 3 the divide code.

Top module: `ltmr_top`

## Requirements
- R1: After reset the control entry reads 0x0001_0000 (masked, one-shot, vector 0). The start count, current count and divide code all read 0. Divide code 0 gives a shift of 1.
- R2: The divide code keeps only write-data bits 3, 1 and 0, and reads back with every other bit zero (writing 0xFFFF_FFFF reads 0xB; writing 0x4 reads 0).
- R3: With v = {bit3, bit1, bit0} of the divide code, the shift is (v+1) mod 8. Only cycles with tick_i high count as base ticks. The current count steps once every 2^shift base ticks counted from the last start-count write.
- R4: A write to address 1 loads the current count with the written value and restarts the prescaler at that edge. A tick in that same cycle is not counted. An expiry scheduled before the write is dropped.
- R5: In one-shot mode (control bit 17 = 0) the current count falls to zero and holds there. Exactly one interrupt is raised, on the step that arrives while the count is zero, which is (start+1) << shift base ticks after the load.
- R6: In repeat mode (control bit 17 = 1) a step at zero reloads the start count. An interrupt is raised every (start+1) << shift base ticks.
- R7: When control bit 16 (mask) is set, no interrupt is raised, but counting and reloading go on unchanged.
- R8: A start count of zero never raises an interrupt, and the current count reads 0.
- R9: irq_valid_o is high for exactly one cycle per expiry: the cycle after the clock edge of the expiring step. irq_vector_o then holds control bits [7:0].
- R10: Switching from repeat to one-shot after at least one reload forces the current count to 0 and stops the timer with no further interrupt. Switching before any reload lets the count run on as one-shot.
- R11: Writes to address 2 (current count) are ignored. Control bits other than [7:0], 16 and 17 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Base tick enable; one counted tick per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address (0 control, 1 start, 2 current, 3 divide) |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 32 | Combinational read data |
| irq_valid_o | output | 1 | One-cycle interrupt request |
| irq_vector_o | output | 8 | Vector that goes with the interrupt request |

## Verification
Assertions check on every cycle that the prescaler and the current count hold still when neither a tick nor a load nor a mode switch occurs. They also check that the current count never exceeds the start count, that a request is a single-cycle pulse raised only while the entry was unmasked, and that every request coincides with a reload or a zero count. Only the bench scenarios can show the expiry timing: whether requests land on the exact cycle given by the start count and each divide code, whether a restart drops the old deadline, and whether the repeat-to-one-shot switch behaves differently before and after the first reload.

// File: rtl/ltmr_pkg.sv
// Shared encodings for the interval timer: register selects, control-entry
// field positions and the divide-code to shift mapping.
package ltmr_pkg;

    localparam int ADDR_W   = 2;
    localparam int VEC_W    = 8;
    localparam int MASK_POS = 16;
    localparam int PER_POS  = 17;
    localparam int SHIFT_W  = 3;
    localparam int CODE_W   = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL = 2'd0,
        SEL_INIT = 2'd1,
        SEL_CUR  = 2'd2,
        SEL_DIV  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             periodic;
        logic             masked;
        logic [VEC_W-1:0] vector;
    } ctrl_t;

    // Stored code {b3,b1,b0} plus one, wrapping modulo 8.
    function automatic logic [SHIFT_W-1:0] code_to_shift(input logic [CODE_W-1:0] code);
        return SHIFT_W'(code + CODE_W'(1));
    endfunction

endpackage

// File: rtl/ltmr_regs.sv
// Register store for the interval timer.
// Holds the control entry, the start count and the compressed divide code.
// It also produces the load pulse and the repeat-to-one-shot switch pulse.
// Assumes DATA_W covers CNT_W and the control field positions.
module ltmr_regs
    import ltmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output ctrl_t             ctrl_o,
    output logic [CNT_W-1:0]  init_o,
    output logic [CODE_W-1:0] code_o,
    output logic              load_o,
    output logic [CNT_W-1:0]  load_val_o,
    output logic              oneshot_sw_o
);

    logic ctrl_we;
    logic div_we;

    // Decode the write strobes for each writable register.
    always_comb begin
        ctrl_we      = wr_en_i && (wr_addr_i == SEL_CTRL);
        div_we       = wr_en_i && (wr_addr_i == SEL_DIV);
        load_o       = wr_en_i && (wr_addr_i == SEL_INIT);
        load_val_o   = wr_data_i[CNT_W-1:0];
        oneshot_sw_o = ctrl_we && ctrl_o.periodic && !wr_data_i[PER_POS];
    end

    // Control entry: resets masked, one-shot, vector 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_o.vector   <= '0;
            ctrl_o.masked   <= 1'b1;
            ctrl_o.periodic <= 1'b0;
        end else if (ctrl_we) begin
            ctrl_o.vector   <= wr_data_i[VEC_W-1:0];
            ctrl_o.masked   <= wr_data_i[MASK_POS];
            ctrl_o.periodic <= wr_data_i[PER_POS];
        end
    end

    // Start count register.
    always_ff @(posedge clk) begin
        if (!rst_n)      init_o <= '0;
        else if (load_o) init_o <= wr_data_i[CNT_W-1:0];
    end

    // Divide code: keeps only data bits 3, 1 and 0.
    always_ff @(posedge clk) begin
        if (!rst_n)      code_o <= '0;
        else if (div_we) code_o <= {wr_data_i[3], wr_data_i[1:0]};
    end

    // R1: a write that does not hit the control entry leaves it unchanged
    assert_ctrl_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_we |=> $stable(ctrl_o));

endmodule

// File: rtl/ltmr_prescale.sv
// Power-of-two prescaler for the interval timer.
// It counts base ticks since the last restart and emits a step every 2^shift
// ticks. A restart clears the count and swallows a tick in the same cycle.
module ltmr_prescale
    import ltmr_pkg::*;
#(
    parameter int SH_W = SHIFT_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic            restart_i,
    input  logic [SH_W-1:0] shift_i,
    output logic            step_o
);

    localparam int PS_W = (1 << SH_W) - 1;

    logic [PS_W-1:0] ps_q;
    logic [PS_W-1:0] ps_mask;

    // Build a mask of the low 'shift' bits.
    always_comb begin
        for (int b = 0; b < PS_W; b++) begin
            ps_mask[b] = (b < int'(shift_i));
        end
    end

    // A step falls on the tick that carries out of the low 'shift' bits.
    always_comb begin
        step_o = tick_i && !restart_i && ((ps_q & ps_mask) == ps_mask);
    end

    // Count ticks since the last restart.
    always_ff @(posedge clk) begin
        if (!rst_n)         ps_q <= '0;
        else if (restart_i) ps_q <= '0;
        else if (tick_i)    ps_q <= ps_q + PS_W'(1);
    end

    // R3: no base tick and no restart means the prescaler holds
    assert_hold_without_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !restart_i) |=> $stable(ps_q));

    // R4: a restart always leaves the prescaler at zero
    assert_restart_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (ps_q == '0));

endmodule

// File: rtl/ltmr_count.sv
// Down counter and expiry logic for the interval timer.
// It loads on a start-count write and decrements on prescaler steps. In
// repeat mode a step at zero reloads; in one-shot mode the counter is spent.
// A repeat-to-one-shot switch after a reload forces the count to zero.
// Assumes load and step never coincide (the prescaler swallows that step).
module ltmr_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic [CNT_W-1:0] init_i,
    input  logic             periodic_i,
    input  logic             masked_i,
    input  logic             oneshot_sw_i,
    output logic [CNT_W-1:0] cur_o,
    output logic             fire_o
);

    logic [CNT_W-1:0] cur_q;
    logic             spent_q;
    logic             wrapped_q;
    logic             at_zero;

    // Decide whether this cycle's step is an expiry that must be reported.
    always_comb begin
        at_zero = (cur_q == '0);
        fire_o  = step_i && !load_i && at_zero && (init_i != '0)
                  && !masked_i && (periodic_i || !spent_q);
        cur_o   = cur_q;
    end

    // Current count, one-shot spent flag and reload-seen flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q     <= '0;
            spent_q   <= 1'b0;
            wrapped_q <= 1'b0;
        end else if (load_i) begin
            cur_q     <= load_val_i;
            spent_q   <= 1'b0;
            wrapped_q <= 1'b0;
        end else if (oneshot_sw_i && wrapped_q) begin
            cur_q     <= '0;
            spent_q   <= 1'b1;
        end else if (step_i) begin
            if (!at_zero) begin
                cur_q <= cur_q - CNT_W'(1);
            end else if (periodic_i && (init_i != '0)) begin
                cur_q     <= init_i;
                wrapped_q <= 1'b1;
            end else begin
                spent_q <= 1'b1;
            end
        end
    end

    // R4: the current count never exceeds the start count
    assert_cur_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q <= init_i);

    // R3: without a step, load or mode switch the count holds
    assert_hold_without_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !load_i && !oneshot_sw_i) |=> $stable(cur_q));

    // R5: once spent in one-shot mode, the count stays zero until a load
    assert_spent_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (spent_q && !periodic_i && !load_i) |=> (cur_q == '0));

endmodule

// File: rtl/ltmr_top.sv
// Top of the programmable interval timer.
// It ties together the register store, the prescaler and the down counter.
// It provides the combinational read mux and registers the one-cycle
// interrupt request with its vector.
module ltmr_top
    import ltmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [31:0]       wr_data_i,
    input  logic [1:0]        rd_addr_i,
    output logic [31:0]       rd_data_o,
    output logic              irq_valid_o,
    output logic [7:0]        irq_vector_o
);

    ctrl_t              ctrl;
    logic [CNT_W-1:0]   init_q;
    logic [CNT_W-1:0]   cur;
    logic [CODE_W-1:0]  code;
    logic [SHIFT_W-1:0] shift;
    logic               load;
    logic [CNT_W-1:0]   load_val;
    logic               oneshot_sw;
    logic               step;
    logic               fire;
    logic [DATA_W-1:0]  ctrl_word;
    logic [DATA_W-1:0]  div_word;

    ltmr_regs #(
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W)
    ) regs_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_en_i),
        .wr_addr_i    (wr_addr_i),
        .wr_data_i    (wr_data_i),
        .ctrl_o       (ctrl),
        .init_o       (init_q),
        .code_o       (code),
        .load_o       (load),
        .load_val_o   (load_val),
        .oneshot_sw_o (oneshot_sw)
    );

    // Map the stored divide code to a prescale shift.
    always_comb shift = code_to_shift(code);

    ltmr_prescale #(
        .SH_W (SHIFT_W)
    ) presc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .restart_i (load),
        .shift_i   (shift),
        .step_o    (step)
    );

    ltmr_count #(
        .CNT_W (CNT_W)
    ) count_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_i       (step),
        .load_i       (load),
        .load_val_i   (load_val),
        .init_i       (init_q),
        .periodic_i   (ctrl.periodic),
        .masked_i     (ctrl.masked),
        .oneshot_sw_i (oneshot_sw),
        .cur_o        (cur),
        .fire_o       (fire)
    );

    // Pack the control fields and divide code into read words.
    always_comb begin
        ctrl_word           = '0;
        ctrl_word[VEC_W-1:0] = ctrl.vector;
        ctrl_word[MASK_POS] = ctrl.masked;
        ctrl_word[PER_POS]  = ctrl.periodic;
        div_word            = '0;
        div_word[3]         = code[2];
        div_word[1:0]       = code[1:0];
    end

    // Combinational read mux.
    always_comb begin
        case (rd_addr_i)
            SEL_CTRL: rd_data_o = ctrl_word;
            SEL_INIT: rd_data_o = DATA_W'(init_q);
            SEL_CUR:  rd_data_o = DATA_W'(cur);
            default:  rd_data_o = div_word;
        endcase
    end

    // Register the interrupt request and capture its vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid_o  <= 1'b0;
            irq_vector_o <= '0;
        end else begin
            irq_valid_o <= fire;
            if (fire) irq_vector_o <= ctrl.vector;
        end
    end

    // R9: a request is a single-cycle pulse
    assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |=> !irq_valid_o);

    // R7: a request only follows a cycle in which the entry was unmasked
    assert_irq_unmasked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |-> !$past(ctrl.masked));

    // R6: a request coincides with a reload or with a zero count
    assert_irq_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |-> ((cur == init_q) || (cur == '0)));

endmodule

// File: tb/ltmr_top_tb_top.sv
`timescale 1ns/1ps
module ltmr_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq_valid;
    logic [7:0]  irq_vector;

    always #2.5 clk = ~clk;

    ltmr_top dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick),
        .wr_en_i      (wr_en),
        .wr_addr_i    (wr_addr),
        .wr_data_i    (wr_data),
        .rd_addr_i    (rd_addr),
        .rd_data_o    (rd_data),
        .irq_valid_o  (irq_valid),
        .irq_vector_o (irq_vector)
    );

    int cyc = 0;
    int total = 0;
    int bad = 0;
    int q_stamp[$];
    logic [7:0] q_vec[$];

    always @(posedge clk) cyc <= cyc + 1;

    // Scoreboard monitor: pops expected requests and compares cycle and vector.
    always @(negedge clk) begin : monitor
        int s;
        logic [7:0] v;
        if (rst_n) begin
            if (irq_valid) begin
                total++;
                if (q_stamp.size() == 0) begin
                    bad++;
                    $display("FAIL R9 unexpected request: actual cycle=%0d vector=%02h expected none", cyc, irq_vector);
                end else begin
                    s = q_stamp.pop_front();
                    v = q_vec.pop_front();
                    if (s != cyc || v != irq_vector) begin
                        bad++;
                        $display("FAIL R9 request: actual cycle=%0d vector=%02h expected cycle=%0d vector=%02h",
                                 cyc, irq_vector, s, v);
                    end
                end
            end else if (q_stamp.size() > 0 && q_stamp[0] < cyc) begin
                total++;
                bad++;
                s = q_stamp.pop_front();
                v = q_vec.pop_front();
                $display("FAIL R5/R6 missing request: actual none by cycle=%0d expected cycle=%0d vector=%02h", cyc, s, v);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string req);
        rd_addr = a;
        #0.5;
        chk(req, rd_data, exp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic expect_irq(input int stamp, input logic [7:0] v);
        q_stamp.push_back(stamp);
        q_vec.push_back(v);
    endtask

    function automatic logic [31:0] cw(input logic [7:0] v, input bit m, input bit p);
        return {14'b0, p, m, 8'b0, v};
    endfunction

    function automatic int shift_of(input logic [31:0] d);
        logic [2:0] v;
        v = {d[3], d[1:0]};
        return (int'(v) + 1) % 8;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : driver
        int e;
        int e2;
        int c0;
        logic [31:0] codes[4];
        codes = '{32'h1, 32'h2, 32'h8, 32'h9};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, 32'h0001_0000, "R1 control after reset");
        rd(2'd1, 32'h0, "R1 start after reset");
        rd(2'd2, 32'h0, "R1 current after reset");
        rd(2'd3, 32'h0, "R1 divide after reset");

        // R2 divide storage
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, 32'hB, "R2 divide keeps bits 3,1,0");
        wr(2'd3, 32'h4);
        rd(2'd3, 32'h0, "R2 divide drops bit 2");
        tick = 1'b1;

        // R5 one-shot, divide by 1
        wr(2'd3, 32'hB);
        wr(2'd0, cw(8'h41, 1'b0, 1'b0));
        rd(2'd0, 32'h0000_0041, "R11 control readback");
        wr(2'd1, 32'd5);
        e = cyc;
        expect_irq(e + (6 << shift_of(32'hB)), 8'h41);
        rd(2'd2, 32'd5, "R4 load sets current");
        wait_to(e + 2);
        rd(2'd2, 32'd3, "R3 count steps each tick");
        wait_to(e + 5);
        rd(2'd2, 32'd0, "R5 reaches zero");
        wait_to(e + 14);
        rd(2'd2, 32'd0, "R5 holds zero after expiry");

        // R6 repeat, divide by 2
        wr(2'd1, 32'd0);
        wr(2'd3, 32'h0);
        wr(2'd0, cw(8'h22, 1'b0, 1'b1));
        wr(2'd1, 32'd3);
        e = cyc;
        expect_irq(e + 8, 8'h22);
        expect_irq(e + 16, 8'h22);
        expect_irq(e + 24, 8'h22);
        wait_to(e + 9);
        rd(2'd2, 32'd3, "R6 reload to start");
        wait_to(e + 25);
        wr(2'd1, 32'd0);
        e2 = cyc;
        rd(2'd2, 32'd0, "R8 zero start reads zero");
        wait_to(e2 + 16);

        // R7 masked repeat keeps counting
        wr(2'd3, 32'hB);
        wr(2'd0, cw(8'h55, 1'b1, 1'b1));
        wr(2'd1, 32'd2);
        e = cyc;
        wait_to(e + 4);
        rd(2'd2, 32'd1, "R7 counts and reloads while masked");
        wait_to(e + 12);
        wr(2'd1, 32'd0);

        // R10 switch after a reload stops the timer
        wr(2'd0, cw(8'h33, 1'b0, 1'b1));
        wr(2'd1, 32'd2);
        e = cyc;
        expect_irq(e + 3, 8'h33);
        wait_to(e + 3);
        wr(2'd0, cw(8'h33, 1'b0, 1'b0));
        rd(2'd2, 32'd0, "R10 switch after reload forces zero");
        wait_to(e + 20);
        rd(2'd2, 32'd0, "R10 stays stopped");

        // R10 switch before a reload continues as one-shot
        wr(2'd1, 32'd0);
        wr(2'd0, cw(8'h34, 1'b0, 1'b1));
        wr(2'd1, 32'd4);
        e = cyc;
        expect_irq(e + 5, 8'h34);
        wait_to(e + 1);
        wr(2'd0, cw(8'h34, 1'b0, 1'b0));
        wait_to(e + 15);
        rd(2'd2, 32'd0, "R10 early switch ends at zero");

        // R4 restart drops the earlier deadline
        wr(2'd1, 32'd0);
        wr(2'd0, cw(8'h66, 1'b0, 1'b0));
        wr(2'd1, 32'd6);
        e = cyc;
        wait_to(e + 3);
        wr(2'd1, 32'd6);
        e2 = cyc;
        expect_irq(e2 + 7, 8'h66);
        rd(2'd2, 32'd6, "R4 restart reloads current");
        wait_to(e2 + 12);

        // R3 divide codes mapping to shifts 2, 3, 5, 6
        foreach (codes[i]) begin
            wr(2'd1, 32'd0);
            wr(2'd3, codes[i]);
            wr(2'd0, cw(8'h70 + 8'(i), 1'b0, 1'b0));
            wr(2'd1, 32'd1);
            e = cyc;
            expect_irq(e + (2 << shift_of(codes[i])), 8'h70 + 8'(i));
            wait_to(e + (2 << shift_of(codes[i])) + 3);
        end
        chk("R3 all divide-code requests seen", 32'(q_stamp.size()), 32'd0);

        // R3 no tick no count; R11 current count not writable
        tick = 1'b0;
        wr(2'd1, 32'd0);
        wr(2'd3, 32'hB);
        wr(2'd0, cw(8'h77, 1'b0, 1'b0));
        wr(2'd1, 32'd7);
        e = cyc;
        wait_to(e + 10);
        rd(2'd2, 32'd7, "R3 no count without tick");
        wr(2'd2, 32'h1234);
        rd(2'd2, 32'd7, "R11 current write ignored");
        rd(2'd1, 32'd7, "R11 start untouched by current write");
        tick = 1'b1;
        c0 = cyc;
        expect_irq(c0 + 8, 8'h77);
        wait_to(c0 + 14);

        chk("R9 no outstanding requests", 32'(q_stamp.size()), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule